// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver with Request/Acknowledge Output

This block listens on an asynchronous serial line and turns each incoming frame into a parallel byte. The line rests high. A frame opens with one low start bit, carries eight data bits with the least significant bit first, and closes with one high stop bit. The block runs on a clock eight times the bit rate. It uses that margin to place every sample close to the centre of its bit, which tolerates small rate and phase differences between sender and receiver.

A finished byte is handed to the consumer through a four-phase handshake. The block raises a request and holds the byte steady. The consumer raises acknowledge. The block drops its request and then waits for acknowledge to fall before it will accept a new frame. A bad stop bit discards the byte and produces a one-cycle error pulse. A synchronous clear aborts any activity.

Top module: `serial_rx_hs`

## Requirements
- R1: While reset is asserted and in the first cycle after it, req_o=0, frame_err_o=0 and data_o=0.
- R2: The serial input passes through a two-flop synchroniser. A high-to-low change of the synchronised line while idle begins a frame. Each bit lasts 8 clocks. The frame is start bit 0, then data bit 0 through data bit 7, then stop bit 1. After a valid frame, req_o is 1 within two clocks after the stop bit ends, and data_o equals the byte.
- R3: Each bit is sampled 4 clocks after its start, taking the start edge as seen at the input. The first two and last two clocks of every data bit therefore have no effect on the captured byte.
- R4: If the line is high again at the start-bit sample, the event is dropped. No request and no error are produced, and the next frame is received normally.
- R5: Only one stop bit is required. Any amount of extra idle-high time after it is accepted without error.
- R6: A stop-bit sample of 0 raises frame_err_o for exactly one clock. In that case req_o stays 0 and data_o keeps its earlier value.
- R7: When ack_i is 1 while req_o is 1, req_o is 0 on the next clock.
- R8: After req_o falls, no frame is accepted until ack_i returns to 0. A frame sent while ack_i is still high produces no request and leaves data_o unchanged.
- R9: While req_o is 1, data_o does not change, and a frame arriving on the line is ignored.
- R10: A one-clock pulse on clr_i returns the block to idle. On the next clock req_o=0, frame_err_o=0 and data_o=0, even in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at eight times the bit rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear to idle |
| rx_i | input | 1 | Asynchronous serial input, idles high |
| ack_i | input | 1 | Acknowledge from the consumer |
| req_o | output | 1 | Byte available request |
| data_o | output | 8 | Received byte |
| frame_err_o | output | 1 | One-cycle pulse on a bad stop bit |

## Verification
The bench uses the default parameters: 8-bit data, a two-flop synchroniser and 8x oversampling. At these values the sample falls exactly four clocks into each bit. The bench can therefore invert the two clocks at each edge of every data bit and expect the byte to come through intact. The 4-clock half-bit also lets a 2-clock low pulse stand for a glitch that is shorter than the start-bit sample distance. The frame length of 80 clocks lets the handshake checks place whole frames inside the request and acknowledge phases.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_REQ,
    ST_WAIT
  } rx_state_e;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '1;
        else         ff_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '1;
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/serial_rx_timer.sv
module serial_rx_timer #(
  parameter int OVERSAMPLE = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic load_half_i,
  input  logic load_full_i,
  output logic tick_o
);
  localparam int CNT_W = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
  localparam int HALF  = OVERSAMPLE / 2;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clr_i)       cnt_q <= '0;
    else if (load_half_i) cnt_q <= CNT_W'(HALF - 1);
    else if (load_full_i) cnt_q <= CNT_W'(OVERSAMPLE - 1);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign tick_o = (cnt_q == '0);

  // R3: a full reload must give a gap of the whole bit before the next tick
  a_r3_full_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_full_i && !clr_i && !load_half_i) |=> !tick_o);
endmodule

// File: rtl/serial_rx_shift.sv
module serial_rx_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              shift_i,
  input  logic              bit_i,
  input  logic              commit_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] sreg_q;
  logic [DATA_W-1:0] out_q;

  // lsb arrives first: insert at the top, shift toward bit 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sreg_q <= '0;
    else if (clr_i)   sreg_q <= '0;
    else if (shift_i) sreg_q <= {bit_i, sreg_q[DATA_W-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       out_q <= '0;
    else if (clr_i)    out_q <= '0;
    else if (commit_i) out_q <= sreg_q;
  end

  assign data_o = out_q;

  // R6: output only moves on commit or clear
  a_r6_out_only_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit_i && !clr_i) |=> $stable(data_o));
endmodule

// File: rtl/serial_rx_ctrl.sv
module serial_rx_ctrl
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic rx_s_i,
  input  logic tick_i,
  input  logic ack_i,
  output logic load_half_o,
  output logic load_full_o,
  output logic shift_o,
  output logic commit_o,
  output logic req_o,
  output logic frame_err_o
);
  localparam int BC_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;

  rx_state_e       state_q, state_d;
  logic [BC_W-1:0] bcnt_q, bcnt_d;
  logic            prev_q;
  logic            ferr_q, ferr_d;
  logic            fall;

  assign fall = prev_q && !rx_s_i;

  always_comb begin
    state_d     = state_q;
    bcnt_d      = bcnt_q;
    ferr_d      = 1'b0;
    load_half_o = 1'b0;
    load_full_o = 1'b0;
    shift_o     = 1'b0;
    commit_o    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (fall) begin
        state_d     = ST_START;
        load_half_o = 1'b1;
      end
      ST_START: if (tick_i) begin
        if (rx_s_i) state_d = ST_IDLE;  // glitch
        else begin
          state_d     = ST_DATA;
          bcnt_d      = '0;
          load_full_o = 1'b1;
        end
      end
      ST_DATA: if (tick_i) begin
        shift_o     = 1'b1;
        load_full_o = 1'b1;
        if (bcnt_q == BC_W'(DATA_W - 1)) state_d = ST_STOP;
        else                            bcnt_d  = bcnt_q + 1'b1;
      end
      ST_STOP: if (tick_i) begin
        if (rx_s_i) begin
          state_d  = ST_REQ;
          commit_o = 1'b1;
        end else begin
          state_d = ST_IDLE;
          ferr_d  = 1'b1;
        end
      end
      ST_REQ:  if (ack_i)  state_d = ST_WAIT;
      ST_WAIT: if (!ack_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bcnt_q  <= '0;
      prev_q  <= 1'b1;
      ferr_q  <= 1'b0;
    end else if (clr_i) begin
      state_q <= ST_IDLE;
      bcnt_q  <= '0;
      prev_q  <= rx_s_i;
      ferr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bcnt_q  <= bcnt_d;
      prev_q  <= rx_s_i;
      ferr_q  <= ferr_d;
    end
  end

  assign req_o       = (state_q == ST_REQ);
  assign frame_err_o = ferr_q;

  a_r7_req_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && ack_i) |=> !req_o);

  a_r8_hold_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && ack_i && !clr_i) |=> (state_q == ST_WAIT && !req_o));

  a_r6_err_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |=> !frame_err_o);

  a_r6_err_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> !req_o);
endmodule

// File: rtl/serial_rx_hs.sv
module serial_rx_hs #(
  parameter int DATA_W      = 8,
  parameter int OVERSAMPLE  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              rx_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [DATA_W-1:0] data_o,
  output logic              frame_err_o
);
  logic rx_s, tick, load_half, load_full, shift, commit;

  serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  serial_rx_timer #(.OVERSAMPLE(OVERSAMPLE)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr_i),
    .load_half_i(load_half),
    .load_full_i(load_full),
    .tick_o     (tick)
  );

  serial_rx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_i),
    .shift_i (shift),
    .bit_i   (rx_s),
    .commit_i(commit),
    .data_o  (data_o)
  );

  serial_rx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr_i),
    .rx_s_i     (rx_s),
    .tick_i     (tick),
    .ack_i      (ack_i),
    .load_half_o(load_half),
    .load_full_o(load_full),
    .shift_o    (shift),
    .commit_o   (commit),
    .req_o      (req_o),
    .frame_err_o(frame_err_o)
  );

  a_r9_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> (!req_o || $stable(data_o)));

  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!req_o && !frame_err_o && data_o == '0));
endmodule

// File: tb/serial_rx_hs_bench.sv
module serial_rx_hs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CYC    = 8;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clr_i = 1'b0;
  logic       rx_i = 1'b1;
  logic       ack_i = 1'b0;
  logic       req_o;
  logic [7:0] data_o;
  logic       frame_err_o;

  int errors = 0;
  int checks = 0;
  int ferr_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  serial_rx_hs u_serial_rx_hs (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .rx_i(rx_i),
    .ack_i(ack_i), .req_o(req_o), .data_o(data_o), .frame_err_o(frame_err_o)
  );

  always @(posedge clk_i) if (frame_err_o) ferr_cnt++;

  // bit 8: stop-bit value, bits 7:0: byte
  localparam logic [8:0] VEC [0:5] = '{
    {1'b1, 8'h41}, {1'b1, 8'h00}, {1'b1, 8'hFF},
    {1'b0, 8'h5A}, {1'b1, 8'hA5}, {1'b1, 8'h80}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int n);
    rx_i = v;
    repeat (n) @(negedge clk_i);
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop_v,
                            input int idle_cyc, input bit corrupt);
    drive(1'b0, BIT_CYC);
    for (int i = 0; i < 8; i++) begin
      if (corrupt) begin
        drive(~b[i], 2); drive(b[i], 4); drive(~b[i], 2);
      end else drive(b[i], BIT_CYC);
    end
    drive(stop_v, BIT_CYC);
    drive(1'b1, idle_cyc);
  endtask

  task automatic handshake(input string tag);
    ack_i = 1'b1;
    @(negedge clk_i);
    check({tag, " R7 req falls after ack"}, req_o, 0);
    drive(1'b1, 3);
    ack_i = 1'b0;
    drive(1'b1, 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [7:0] last;
    int fe0;
    repeat (3) @(negedge clk_i);
    check("R1 req in reset", req_o, 0);
    check("R1 data in reset", data_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 req after reset", req_o, 0);
    check("R1 ferr after reset", frame_err_o, 0);
    check("R1 data after reset", data_o, 0);
    drive(1'b1, 10);

    // R2/R6 vector walk
    last = 8'h00;
    foreach (VEC[i]) begin
      fe0 = ferr_cnt;
      send_frame(VEC[i][7:0], VEC[i][8], 4, 1'b0);
      if (VEC[i][8]) begin
        check("R2 req after frame", req_o, 1);
        check("R2 data lsb first", data_o, VEC[i][7:0]);
        check("R2 no frame error", ferr_cnt - fe0, 0);
        last = VEC[i][7:0];
        handshake("R2");
      end else begin
        check("R6 one error pulse", ferr_cnt - fe0, 1);
        check("R6 no req", req_o, 0);
        check("R6 data kept", data_o, last);
      end
    end

    // R3 edges of each data bit corrupted
    send_frame(8'hC6, 1'b1, 4, 1'b1);
    check("R3 centre sampling req", req_o, 1);
    check("R3 centre sampling data", data_o, 8'hC6);
    handshake("R3");

    // R4 short low pulse
    fe0 = ferr_cnt;
    drive(1'b0, 2);
    drive(1'b1, 100);
    check("R4 glitch no req", req_o, 0);
    check("R4 glitch no error", ferr_cnt - fe0, 0);
    send_frame(8'h3E, 1'b1, 4, 1'b0);
    check("R4 frame after glitch", data_o, 8'h3E);
    handshake("R4");

    // R5 long idle after stop
    fe0 = ferr_cnt;
    send_frame(8'h71, 1'b1, 60, 1'b0);
    check("R5 long stop data", data_o, 8'h71);
    check("R5 long stop no error", ferr_cnt - fe0, 0);
    handshake("R5");
    send_frame(8'h12, 1'b1, 4, 1'b0);
    check("R5 next frame data", data_o, 8'h12);
    handshake("R5b");

    // R9 frame during request ignored
    send_frame(8'h9C, 1'b1, 4, 1'b0);
    send_frame(8'h63, 1'b1, 4, 1'b0);
    check("R9 req held", req_o, 1);
    check("R9 data held", data_o, 8'h9C);
    handshake("R9");
    drive(1'b1, 20);
    check("R9 ignored frame no req", req_o, 0);

    // R8 frame while ack still high
    send_frame(8'h2B, 1'b1, 4, 1'b0);
    ack_i = 1'b1;
    drive(1'b1, 2);
    send_frame(8'hD4, 1'b1, 4, 1'b0);
    ack_i = 1'b0;
    drive(1'b1, 20);
    check("R8 no req from masked frame", req_o, 0);
    check("R8 data unchanged", data_o, 8'h2B);
    send_frame(8'h4D, 1'b1, 4, 1'b0);
    check("R8 accepts after ack low", data_o, 8'h4D);
    handshake("R8");

    // R10 clear in the middle of a frame
    drive(1'b0, BIT_CYC);
    drive(1'b1, 12);
    clr_i = 1'b1;
    @(negedge clk_i);
    clr_i = 1'b0;
    check("R10 data cleared", data_o, 0);
    check("R10 req low", req_o, 0);
    drive(1'b1, 100);
    check("R10 no req after abort", req_o, 0);
    check("R10 data stays zero", data_o, 0);
    // R10 clear while request is up
    send_frame(8'hE7, 1'b1, 4, 1'b0);
    check("R10 pre-clear req", req_o, 1);
    clr_i = 1'b1;
    @(negedge clk_i);
    clr_i = 1'b0;
    check("R10 req cleared", req_o, 0);
    check("R10 data cleared in req", data_o, 0);
    send_frame(8'h5B, 1'b1, 4, 1'b0);
    check("R10 recovers", data_o, 8'h5B);
    handshake("R10");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule